// File: doc/BRIEF.md
# Peripheral-Triggered DMA Channel Sequencer

This block is the control sequencer of one DMA channel that a peripheral can start. Four peripheral request lines come in, and a route field selects the one that drives the channel. The selected line passes through a two-flop synchronizer. It starts work only when the external-trigger enable is set, the channel is waiting (state IDLE or PAUSE), and bytes remain in the count. Address generation and bus arbitration are outside the block. The width of each write arrives on `xfer_bytes` from the size logic next door.

Each unit of work is one read phase and then one write phase on a simple master handshake. A phase holds its strobe until `bus_ack` is seen at a clock edge. After each acknowledged write the remaining byte count drops by the write width, stopping at zero.

The steal bit selects one of two modes:
- **Steal mode:** each rising edge of the synchronized request moves exactly one read/write pair, and the channel then waits in PAUSE.
- **Burst mode:** a level request starts a run of pairs that continues until the count is used up.

When the count reaches zero the channel enters DONE. It stays there until software writes a 1 to `done_w1c`, which returns it to IDLE.

States and transitions:
- IDLE→READ: a start is accepted.
- READ→WRITE: read acknowledged.
- WRITE→READ: write acknowledged, burst mode, bytes left.
- WRITE→PAUSE: write acknowledged, steal mode, bytes left.
- WRITE→DONE: write acknowledged, count reaches zero.
- PAUSE→READ: a start is accepted.
- DONE→IDLE: `done_w1c` is written.

Top module: `pdma_seq`

## Requirements
- R1: After reset the channel is in IDLE: `bus_rd`, `bus_wr`, `busy` and `done` are 0, and `bytes_left` is 0.
- R2: Only the request line whose index equals `cfg_route` can start the channel; the other lines have no effect.
- R3: While `cfg_ext_en` is 0, no request starts the channel.
- R4: A request that rises at the port shows `bus_rd` high after the third rising clock edge (two synchronizer stages, one state register).
- R5: Each transaction is a read phase and then a write phase. `bus_rd` stays high until acknowledged, an acknowledged read is followed directly by `bus_wr`, and the two strobes are never high together.
- R6: In steal mode (`cfg_steal`=1), each rising edge of the selected request moves exactly one read/write pair. A request held high does not start another.
- R7: In burst mode (`cfg_steal`=0), one request runs read/write pairs back to back until `bytes_left` reaches zero.
- R8: Each acknowledged write lowers `bytes_left` by `xfer_bytes`, saturating at zero.
- R9: `done` rises when `bytes_left` reaches zero and holds until `done_w1c` is 1. That write returns the channel to IDLE, and no strobe is driven while `done` is high.
- R10: A request edge that arrives while a transaction is in flight is dropped, not queued.
- R11: `cnt_load` loads `cnt_value` into `bytes_left` only in IDLE. During a transaction the count changes only on an acknowledged write.
- R12: With `bytes_left` equal to zero, a request does not start the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| preq | input | NREQ (4) | Peripheral request lines, asynchronous |
| cfg_route | input | clog2(NREQ) (2) | Index of the request line that drives the channel |
| cfg_ext_en | input | 1 | External-trigger enable |
| cfg_steal | input | 1 | 1: one read/write pair per request edge; 0: burst to end of count |
| cnt_load | input | 1 | Load strobe for the byte count (accepted in IDLE) |
| cnt_value | input | CNT_W (24) | Byte count to load |
| done_w1c | input | 1 | Write-1 clear of the done flag |
| xfer_bytes | input | SZ_W (3) | Width in bytes of the current write |
| bus_rd | output | 1 | Read phase strobe |
| bus_wr | output | 1 | Write phase strobe |
| bus_ack | input | 1 | Phase acknowledge from the bus |
| busy | output | 1 | Transaction in flight (READ or WRITE) |
| done | output | 1 | Count exhausted status flag |
| bytes_left | output | CNT_W (24) | Remaining byte count |

## Verification
The checker watches these rules on every cycle:
- the handshake ordering and strobe exclusivity;
- the saturating count step after each acknowledged write;
- the count holding still during a transaction;
- the done flag persisting until cleared and returning to IDLE when cleared;
- no start while the enable is off or the count is zero.

Other behaviours depend on sequences of stimulus, so only the bench scenarios can show them. These are the route selection, the exact three-edge start latency, one pair per edge in steal mode with a held request, a full burst from a single request, and a request edge dropped while a slowly acknowledged transaction is in flight.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WRITE = 3'd2,
        ST_PAUSE = 3'd3,
        ST_DONE  = 3'd4
    } chan_state_t;

endpackage

// File: rtl/pdma_req_sync.sv
// Selects one request line, synchronizes it and qualifies it as level or edge.
module pdma_req_sync #(
    parameter int NREQ  = 4,
    parameter int SEL_W = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREQ-1:0]  preq,
    input  logic [SEL_W-1:0] route,
    input  logic             edge_mode,
    output logic             trig
);
    logic sel_raw;
    logic [2:0] sync_q;   // [0],[1] synchronizer, [2] history for edge detect

    assign sel_raw = preq[route];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], sel_raw};
        end
    end

    assign trig = edge_mode ? (sync_q[1] & ~sync_q[2]) : sync_q[1];
endmodule

// File: rtl/pdma_bcnt.sv
// Remaining byte count with saturating decrement.
module pdma_bcnt #(
    parameter int CNT_W = 24,
    parameter int SZ_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    input  logic [SZ_W-1:0]  dec_bytes,
    output logic [CNT_W-1:0] cnt,
    output logic             last,
    output logic             zero
);
    localparam int PAD_W = CNT_W - SZ_W;

    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] cnt_next;

    assign step     = {{PAD_W{1'b0}}, dec_bytes};
    assign last     = (step >= cnt);
    assign zero     = (cnt == '0);
    assign cnt_next = last ? '0 : (cnt - step);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt_next;
        end
    end
endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
    import pdma_pkg::*;
#(
    parameter int NREQ  = 4,
    parameter int CNT_W = 24,
    parameter int SZ_W  = 3,
    localparam int SEL_W = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREQ-1:0]  preq,
    input  logic [SEL_W-1:0] cfg_route,
    input  logic             cfg_ext_en,
    input  logic             cfg_steal,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_value,
    input  logic             done_w1c,
    input  logic [SZ_W-1:0]  xfer_bytes,
    output logic             bus_rd,
    output logic             bus_wr,
    input  logic             bus_ack,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] bytes_left
);
    chan_state_t state_q, state_d;
    logic trig;
    logic wr_done;
    logic cnt_last;
    logic cnt_zero;
    logic start_ok;

    pdma_req_sync #(.NREQ(NREQ), .SEL_W(SEL_W)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .preq      (preq),
        .route     (cfg_route),
        .edge_mode (cfg_steal),
        .trig      (trig)
    );

    assign wr_done = (state_q == ST_WRITE) && bus_ack;

    pdma_bcnt #(.CNT_W(CNT_W), .SZ_W(SZ_W)) u_bcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load && (state_q == ST_IDLE)),
        .load_val  (cnt_value),
        .dec       (wr_done),
        .dec_bytes (xfer_bytes),
        .cnt       (bytes_left),
        .last      (cnt_last),
        .zero      (cnt_zero)
    );

    assign start_ok = cfg_ext_en && trig && !cnt_zero;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_ok) state_d = ST_READ;
            ST_READ:  if (bus_ack)  state_d = ST_WRITE;
            ST_WRITE: begin
                if (bus_ack) begin
                    if (cnt_last)       state_d = ST_DONE;
                    else if (cfg_steal) state_d = ST_PAUSE;
                    else                state_d = ST_READ;
                end
            end
            ST_PAUSE: if (start_ok) state_d = ST_READ;
            ST_DONE:  if (done_w1c) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        bus_rd = 1'b0;
        bus_wr = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_READ:  bus_rd = 1'b1;
            ST_WRITE: bus_wr = 1'b1;
            ST_DONE:  done   = 1'b1;
            default:  ;
        endcase
        busy = bus_rd | bus_wr;
    end
endmodule

// File: rtl/pdma_seq_chk.sv
module pdma_seq_chk #(
    parameter int CNT_W = 24,
    parameter int SZ_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_ext_en,
    input logic             done_w1c,
    input logic [SZ_W-1:0]  xfer_bytes,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic             bus_ack,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] bytes_left
);
    function automatic logic [CNT_W-1:0] sat_sub(input logic [CNT_W-1:0] a,
                                                 input logic [SZ_W-1:0] b);
        logic [CNT_W-1:0] bw;
        bw = {{(CNT_W-SZ_W){1'b0}}, b};
        return (bw >= a) ? '0 : (a - bw);
    endfunction

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ack) |=> bus_rd);
    assert_rd_then_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_ack) |=> bus_wr);
    assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_ack) |=> bytes_left == sat_sub($past(bytes_left), $past(xfer_bytes)));
    assert_cnt_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(bus_wr && bus_ack)) |=> $stable(bytes_left));
    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_w1c) |=> done);
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_rd && !bus_wr));
    assert_done_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_w1c) |=> (!done && !busy));
    assert_no_start_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg_ext_en) |=> !busy);
    assert_no_start_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bytes_left == '0) |=> !busy);
endmodule

bind pdma_seq pdma_seq_chk #(.CNT_W(CNT_W), .SZ_W(SZ_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_ext_en (cfg_ext_en),
    .done_w1c   (done_w1c),
    .xfer_bytes (xfer_bytes),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_ack    (bus_ack),
    .busy       (busy),
    .done       (done),
    .bytes_left (bytes_left)
);

// File: tb/tb_pdma_seq.sv
module tb_pdma_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NREQ  = 4;
    localparam int CNT_W = 24;
    localparam int SZ_W  = 3;
    localparam int WATCHDOG = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NREQ-1:0]  preq = '0;
    logic [1:0]       cfg_route = '0;
    logic             cfg_ext_en = 1'b0;
    logic             cfg_steal = 1'b0;
    logic             cnt_load = 1'b0;
    logic [CNT_W-1:0] cnt_value = '0;
    logic             done_w1c = 1'b0;
    logic [SZ_W-1:0]  xfer_bytes = 3'd1;
    logic             bus_rd, bus_wr, busy, done;
    logic             bus_ack = 1'b0;
    logic [CNT_W-1:0] bytes_left;

    int n_checks = 0;
    int n_fails  = 0;
    int ack_lat  = 0;
    int hold_cnt = 0;
    int exp_q[$];
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdma_seq #(.NREQ(NREQ), .CNT_W(CNT_W), .SZ_W(SZ_W)) dut (
        .clk(clk), .rst_n(rst_n), .preq(preq), .cfg_route(cfg_route),
        .cfg_ext_en(cfg_ext_en), .cfg_steal(cfg_steal), .cnt_load(cnt_load),
        .cnt_value(cnt_value), .done_w1c(done_w1c), .xfer_bytes(xfer_bytes),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ack(bus_ack), .busy(busy),
        .done(done), .bytes_left(bytes_left)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    // driver: expected remaining count before each write of a block
    task automatic expect_writes(input int count, input int bytes, input int nwr);
        int c = count;
        for (int i = 0; i < nwr && c > 0; i++) begin
            exp_q.push_back(c);
            c = (bytes >= c) ? 0 : c - bytes;
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_count(input int v);
        cnt_value = v[CNT_W-1:0];
        cnt_load  = 1'b1;
        @(negedge clk);
        cnt_load  = 1'b0;
    endtask

    // bus responder + monitor (scoreboard pop), all at negedge
    always @(negedge clk) begin
        if (bus_rd || bus_wr) begin
            if (hold_cnt == ack_lat) begin
                bus_ack  = 1'b1;
                hold_cnt = 0;
                if (bus_wr) begin
                    if (exp_q.size() == 0) begin
                        check("R8 unexpected write", int'(bytes_left), -1);
                    end else begin
                        check("R8 count before write", int'(bytes_left), exp_q.pop_front());
                    end
                end
            end else begin
                bus_ack = 1'b0;
                hold_cnt++;
            end
        end else begin
            bus_ack  = 1'b0;
            hold_cnt = 0;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int lat;
        wait_cyc(3);
        // R1: reset state
        check("R1 bus_rd", bus_rd, 0);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 bytes_left", int'(bytes_left), 0);
        rst_n = 1'b1;
        wait_cyc(2);

        // R6/R4: steal mode, route 2, 4-byte writes, held request
        cfg_route = 2'd2; cfg_ext_en = 1'b1; cfg_steal = 1'b1; xfer_bytes = 3'd4;
        load_count(8);
        expect_writes(8, 4, 1);
        preq[2] = 1'b1;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!bus_rd && lat < 20);
        check("R4 start latency", lat, 3);
        wait_cyc(12);
        check("R6 one pair per edge", int'(bytes_left), 4);
        check("R6 not done", done, 0);
        preq[2] = 1'b0; wait_cyc(3);
        expect_writes(4, 4, 1);
        preq[2] = 1'b1; wait_cyc(10);
        check("R8 count zero", int'(bytes_left), 0);
        check("R9 done set", done, 1);
        preq[2] = 1'b0;
        wait_cyc(3);
        check("R9 done held", done, 1);
        done_w1c = 1'b1; @(negedge clk); done_w1c = 1'b0;
        check("R9 done cleared", done, 0);
        check("R9 back to idle", busy, 0);

        // R2: unselected line ignored
        cfg_route = 2'd1;
        load_count(6);
        check("R11 load in idle", int'(bytes_left), 6);
        preq[0] = 1'b1; preq[3] = 1'b1; wait_cyc(10);
        check("R2 other lines ignored", int'(bytes_left), 6);
        check("R2 no busy", busy, 0);
        preq = '0; wait_cyc(2);

        // R3: enable off
        cfg_ext_en = 1'b0;
        preq[1] = 1'b1; wait_cyc(10);
        check("R3 disabled ignored", int'(bytes_left), 6);
        preq[1] = 1'b0; wait_cyc(4);
        cfg_ext_en = 1'b1;

        // R7/R8/R11: burst, 6 bytes by 4 -> saturates
        cfg_steal = 1'b0;
        expect_writes(6, 4, 4);
        preq[1] = 1'b1;
        do @(negedge clk); while (!bus_rd);
        cnt_value = 24'd100; cnt_load = 1'b1; @(negedge clk); cnt_load = 1'b0;
        wait_cyc(10);
        check("R7 burst finished", int'(bytes_left), 0);
        check("R7 done after burst", done, 1);
        check("R11 busy load ignored", exp_q.size(), 0);
        done_w1c = 1'b1; @(negedge clk); done_w1c = 1'b0;
        wait_cyc(10);
        check("R12 empty count no start", busy, 0);
        check("R12 still idle", done, 0);
        preq[1] = 1'b0; wait_cyc(3);

        // R10: edge during slow transaction dropped
        cfg_steal = 1'b1; xfer_bytes = 3'd2; ack_lat = 6;
        load_count(12);
        expect_writes(12, 2, 1);
        preq[1] = 1'b1;
        do @(negedge clk); while (!bus_rd);
        preq[1] = 1'b0; wait_cyc(2);
        preq[1] = 1'b1; wait_cyc(40);
        check("R10 busy edge dropped", int'(bytes_left), 10);
        check("R10 waiting", busy, 0);
        ack_lat = 0;
        preq[1] = 1'b0;
        wait_cyc(3);
        check("R8 all writes seen", exp_q.size(), 0);
        summary();
    end
endmodule